// File: doc/BRIEF.md
# Single DMA Channel with Ring Wrap and Chaining

This block is one channel of a direct memory access engine. It moves a programmed number of transfers from a source pointer to a destination pointer through two independent memory ports, each a request/ready handshake. A transfer can be a byte, a half-word or a word. Either pointer may step by the transfer size or stay fixed, for example on a peripheral data register. Either pointer may also be confined to a power-of-two ring so that it wraps inside an aligned window. The bytes of a half-word or word can be reversed on the way through.

Software programs the channel through a small register port. Some register slots only store a value. Other slots also launch the channel, so a second channel can program and start this one by writing a pair of adjacent words. A peripheral request line can pace the beats. At the end of a sequence the channel can raise an interrupt and send a chain pulse that names another channel. In quiet mode the interrupt comes only from a zero write to a launching slot, which also stops a chain. Read and write bus errors set sticky flags and stop the channel.

Top module: `dma_ring_chan`

## Requirements
- R1: After reset the control view, pointers and remaining count read as zero. No request, interrupt or chain pulse is active.
- R2: Control bits [2:1] select the transfer size: 0 byte, 1 half-word, 2 word. The count is in transfers. Byte lanes are enabled from the low write address bits: one lane for a byte, lanes {1,0} or {3,2} for a half-word, all four for a word. Narrow data is copied into every lane of the 32-bit write data. Only one beat is held at a time, so a read and a write request are never active together.
- R3: The read pointer advances by the transfer size after each accepted read when bit 3 is set, and the write pointer after each accepted write when bit 4 is set. Otherwise each pointer keeps its value. The pointers read back at index 1 (read) and index 2 (write).
- R4: When ring bits [8:5] are nonzero, only that many low bits of the selected pointer change on a step, so it wraps inside an aligned window of 2^ring bytes. A value of zero turns wrapping off.
- R5: Bit 9 picks the pointer that wraps: 0 the read pointer, 1 the write pointer.
- R6: When bit 21 is set, the bytes of a half-word or word are reversed before the write. Bytes are unchanged.
- R7: Bits [19:14] select a pacing request line. A value below the number of lines means a beat starts only while that line is high. Any larger value runs unpaced.
- R8: With quiet bit 20 clear, a one-cycle interrupt pulse follows the end of every completed sequence.
- R9: With quiet set, a completed sequence raises no interrupt. A zero write to a launching slot (index 4 or 7) does not start the channel, and it pulses the interrupt when quiet was set before the write.
- R10: At the end of a sequence a chain pulse is sent together with the target in bits [13:10], unless the target equals the channel's own number. A chain input pulse starts an idle, enabled channel.
- R11: A read or write error response stops the channel and sets sticky flag bit 29 (read) or 30 (write). Bit 31 is their OR. Writing 1 to bit 29 or 30 at index 0 or 4 clears that flag. A stopped channel gives no interrupt or chain pulse.
- R12: Busy (bit 24) is high from start to the end of the sequence. Index 3 and index 6 read the remaining count, which drops by one on each accepted write. A write to either index sets the count for the next start.
- R13: A nonzero write to index 4 stores the control value and starts the channel if its enable bit 0 is set. A nonzero write to index 7 loads the read pointer and starts an enabled channel. Writes to indices 0–3 and 6 never start it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx |
| rd_req | output | 1 | Read request, held until rd_ready |
| rd_addr | output | 32 | Read byte address |
| rd_ready | input | 1 | Read accepted, data valid |
| rd_data | input | 32 | Read data word, lane aligned |
| rd_fault | input | 1 | Error response with rd_ready |
| wr_req | output | 1 | Write request, held until wr_ready |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data, narrow data replicated |
| wr_be | output | 4 | Write byte enables |
| wr_ready | input | 1 | Write accepted |
| wr_fault | input | 1 | Error response with wr_ready |
| pace_req | input | NREQ | Pacing request lines |
| chain_in | input | 1 | Start pulse from another channel |
| chain_out | output | 1 | End-of-sequence chain pulse |
| chain_target | output | 4 | Channel named by chain_out |
| irq | output | 1 | Interrupt pulse |

## Verification
Word copies with both pointers stepping give a baseline for pointer arithmetic and count handling. Random mixes of size, increment flags, ring size, ring side and byte swap, all running under random memory wait states, separate a wrong stride from a wrong wrap mask and from wrong lane placement. Directed runs cover the rest: a held-low pacing line shows no beat leaks, and a quiet run followed by a zero launch write separates the two interrupt sources. A chain target other than the channel's own number, and a start from chain_in, exercise chaining. A start through the count/read-pointer slot pair and faults injected on a chosen read or write address cover those paths, and the fault runs also confirm the sticky flags and their clearing.

// File: rtl/dma_ring_pkg.sv
package dma_ring_pkg;
  localparam int ADDR_W   = 32;
  localparam int F_EN     = 0;
  localparam int F_SIZE   = 1;
  localparam int F_INC_RD = 3;
  localparam int F_INC_WR = 4;
  localparam int F_RING   = 5;
  localparam int F_RINGWR = 9;
  localparam int F_CHAIN  = 10;
  localparam int F_PACE   = 14;
  localparam int F_QUIET  = 20;
  localparam int F_SWAP   = 21;
  localparam int CTRL_W   = 22;
  localparam int F_BUSY   = 24;
  localparam int F_RDERR  = 29;
  localparam int F_WRERR  = 30;

  typedef enum logic [2:0] {
    RI_CTRL      = 3'd0,
    RI_RDPTR     = 3'd1,
    RI_WRPTR     = 3'd2,
    RI_COUNT     = 3'd3,
    RI_CTRL_GO   = 3'd4,
    RI_SPARE     = 3'd5,
    RI_COUNT_ALT = 3'd6,
    RI_RDPTR_GO  = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {ST_IDLE, ST_PACE, ST_READ, ST_WRITE} chan_state_e;

  function automatic logic [1:0] eff_size(input logic [1:0] size);
    return (size == 2'd3) ? 2'd2 : size;
  endfunction

  function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] addr,
                                                 input logic [1:0] size,
                                                 input logic inc, input logic wrap,
                                                 input logic [3:0] ring_bits);
    logic [ADDR_W-1:0] nxt, keep;
    nxt  = addr + (inc ? (ADDR_W'(1) << eff_size(size)) : '0);
    keep = wrap ? ((ADDR_W'(1) << ring_bits) - ADDR_W'(1)) : '1;
    return (addr & ~keep) | (nxt & keep);
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] lo, input logic [1:0] size);
    case (eff_size(size))
      2'd0:    return 4'b0001 << lo;
      2'd1:    return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] shape_data(input logic [31:0] rdata, input logic [1:0] lo,
                                             input logic [1:0] size, input logic swap);
    logic [7:0]  b;
    logic [15:0] h;
    logic [31:0] w;
    case (eff_size(size))
      2'd0: begin
        b = rdata[8*lo +: 8];
        return {4{b}};
      end
      2'd1: begin
        h = rdata[16*lo[1] +: 16];
        if (swap) h = {h[7:0], h[15:8]};
        return {2{h}};
      end
      default: begin
        w = rdata;
        if (swap) w = {w[7:0], w[15:8], w[23:16], w[31:24]};
        return w;
      end
    endcase
  endfunction
endpackage

// File: rtl/dma_ring_ptr.sv
module dma_ring_ptr
  import dma_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              advance,
  input  logic [1:0]        size,
  input  logic              inc,
  input  logic              wrap,
  input  logic [3:0]        ring_bits,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (load)    ptr_q <= load_val;
    else if (advance) ptr_q <= step_ptr(ptr_q, size, inc, wrap, ring_bits);
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/dma_ring_lane.sv
module dma_ring_lane
  import dma_ring_pkg::*;
(
  input  logic [31:0] rdata,
  input  logic [1:0]  rd_lo,
  input  logic [1:0]  wr_lo,
  input  logic [1:0]  size,
  input  logic        swap,
  output logic [31:0] shaped,
  output logic [3:0]  be
);
  assign shaped = shape_data(rdata, rd_lo, size, swap);
  assign be     = lane_mask(wr_lo, size);
endmodule

// File: rtl/dma_ring_seq.sv
module dma_ring_seq
  import dma_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] reload,
  input  logic        pace_ok,
  input  logic        rd_ready,
  input  logic        rd_fault,
  input  logic        wr_ready,
  input  logic        wr_fault,
  output logic        busy,
  output logic [31:0] remaining,
  output logic        rd_req,
  output logic        wr_req,
  output logic        rd_beat,
  output logic        wr_beat,
  output logic        rd_err_hit,
  output logic        wr_err_hit,
  output logic        seq_done
);
  chan_state_e state_q;
  logic [31:0] rem_q;

  assign busy       = (state_q != ST_IDLE);
  assign rd_req     = (state_q == ST_READ);
  assign wr_req     = (state_q == ST_WRITE);
  assign rd_beat    = rd_req && rd_ready && !rd_fault;
  assign wr_beat    = wr_req && wr_ready && !wr_fault;
  assign rd_err_hit = rd_req && rd_ready && rd_fault;
  assign wr_err_hit = wr_req && wr_ready && wr_fault;
  assign seq_done   = (state_q == ST_PACE) && (rem_q == '0);
  assign remaining  = rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_PACE;
          rem_q   <= reload;
        end
        ST_PACE: begin
          if (rem_q == '0) state_q <= ST_IDLE;
          else if (pace_ok) state_q <= ST_READ;
        end
        ST_READ: if (rd_ready) state_q <= rd_fault ? ST_IDLE : ST_WRITE;
        ST_WRITE: if (wr_ready) begin
          if (wr_fault) state_q <= ST_IDLE;
          else begin
            rem_q   <= rem_q - 32'd1;
            state_q <= ST_PACE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_ring_chan.sv
module dma_ring_chan
  import dma_ring_pkg::*;
#(
  parameter int CH_ID = 0,
  parameter int NREQ  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_idx,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            rd_req,
  output logic [31:0]     rd_addr,
  input  logic            rd_ready,
  input  logic [31:0]     rd_data,
  input  logic            rd_fault,
  output logic            wr_req,
  output logic [31:0]     wr_addr,
  output logic [31:0]     wr_data,
  output logic [3:0]      wr_be,
  input  logic            wr_ready,
  input  logic            wr_fault,
  input  logic [NREQ-1:0] pace_req,
  input  logic            chain_in,
  output logic            chain_out,
  output logic [3:0]      chain_target,
  output logic            irq
);
  localparam logic [3:0] SELF = 4'(CH_ID);

  reg_idx_e          ri;
  logic [CTRL_W-1:0] ctrl_q;
  logic [31:0]       reload_q, data_q, shaped, remaining;
  logic              rd_err_q, wr_err_q, irq_q, chain_q;
  logic              busy, rd_beat, wr_beat, rd_err_hit, wr_err_hit, seq_done;
  logic              pace_ok, ctrl_wr, trig_wr, null_trig, start;

  logic              cf_en, cf_inc_rd, cf_inc_wr, cf_ring_wr, cf_quiet, cf_swap;
  logic [1:0]        cf_size;
  logic [3:0]        cf_ring, cf_chain;
  logic [5:0]        cf_pace;

  assign ri         = reg_idx_e'(reg_idx);
  assign cf_en      = ctrl_q[F_EN];
  assign cf_size    = ctrl_q[F_SIZE +: 2];
  assign cf_inc_rd  = ctrl_q[F_INC_RD];
  assign cf_inc_wr  = ctrl_q[F_INC_WR];
  assign cf_ring    = ctrl_q[F_RING +: 4];
  assign cf_ring_wr = ctrl_q[F_RINGWR];
  assign cf_chain   = ctrl_q[F_CHAIN +: 4];
  assign cf_pace    = ctrl_q[F_PACE +: 6];
  assign cf_quiet   = ctrl_q[F_QUIET];
  assign cf_swap    = ctrl_q[F_SWAP];

  // Register-side events, brought out by name for the checker.
  assign ctrl_wr   = reg_we && (ri == RI_CTRL || ri == RI_CTRL_GO);
  assign trig_wr   = reg_we && (ri == RI_CTRL_GO || ri == RI_RDPTR_GO);
  assign null_trig = trig_wr && (reg_wdata == '0);
  assign start     = !busy && (((trig_wr && !null_trig) &&
                               ((ri == RI_CTRL_GO) ? reg_wdata[F_EN] : cf_en)) ||
                               (chain_in && cf_en));

  always_comb begin
    pace_ok = 1'b1;
    for (int k = 0; k < NREQ; k++)
      if (cf_pace == 6'(k)) pace_ok = pace_req[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      rd_err_q <= 1'b0;
      wr_err_q <= 1'b0;
      irq_q    <= 1'b0;
      chain_q  <= 1'b0;
      data_q   <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (reg_we && (ri == RI_COUNT || ri == RI_COUNT_ALT)) reload_q <= reg_wdata;
      if (rd_err_hit)                          rd_err_q <= 1'b1;
      else if (ctrl_wr && reg_wdata[F_RDERR])  rd_err_q <= 1'b0;
      if (wr_err_hit)                          wr_err_q <= 1'b1;
      else if (ctrl_wr && reg_wdata[F_WRERR])  wr_err_q <= 1'b0;
      irq_q   <= (seq_done && !cf_quiet) || (null_trig && cf_quiet);
      chain_q <= seq_done && (cf_chain != SELF);
      if (rd_beat) data_q <= shaped;
    end
  end

  dma_ring_seq u_seq (
    .clk, .rst_n, .start, .reload(reload_q), .pace_ok,
    .rd_ready, .rd_fault, .wr_ready, .wr_fault,
    .busy, .remaining, .rd_req, .wr_req, .rd_beat, .wr_beat,
    .rd_err_hit, .wr_err_hit, .seq_done
  );

  // Pointer 0 is the read side, pointer 1 the write side.
  logic [1:0]  ptr_load, ptr_adv, ptr_inc;
  logic [31:0] ptr_val [2];
  assign ptr_load = {reg_we && ri == RI_WRPTR, reg_we && (ri == RI_RDPTR || ri == RI_RDPTR_GO)};
  assign ptr_adv  = {wr_beat, rd_beat};
  assign ptr_inc  = {cf_inc_wr, cf_inc_rd};

  for (genvar g = 0; g < 2; g++) begin : g_ptr
    dma_ring_ptr u_ptr (
      .clk, .rst_n,
      .load(ptr_load[g]), .load_val(reg_wdata), .advance(ptr_adv[g]),
      .size(cf_size), .inc(ptr_inc[g]),
      .wrap((cf_ring != 4'd0) && (cf_ring_wr == 1'(g))),
      .ring_bits(cf_ring), .ptr(ptr_val[g])
    );
  end

  dma_ring_lane u_lane (
    .rdata(rd_data), .rd_lo(ptr_val[0][1:0]), .wr_lo(ptr_val[1][1:0]),
    .size(cf_size), .swap(cf_swap), .shaped, .be(wr_be)
  );

  assign rd_addr      = ptr_val[0];
  assign wr_addr      = ptr_val[1];
  assign wr_data      = data_q;
  assign irq          = irq_q;
  assign chain_out    = chain_q;
  assign chain_target = cf_chain;

  always_comb begin
    case (ri)
      RI_CTRL, RI_CTRL_GO: reg_rdata = {rd_err_q | wr_err_q, wr_err_q, rd_err_q, 4'b0,
                                        busy, 2'b0, ctrl_q};
      RI_RDPTR, RI_RDPTR_GO: reg_rdata = ptr_val[0];
      RI_WRPTR:              reg_rdata = ptr_val[1];
      RI_COUNT, RI_COUNT_ALT: reg_rdata = remaining;
      default:               reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_ring_chan_chk.sv
module dma_ring_chan_chk #(
  parameter int CH_ID = 0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic        rd_ready,
  input logic [31:0] rd_addr,
  input logic        wr_req,
  input logic [3:0]  wr_be,
  input logic [1:0]  size,
  input logic        busy,
  input logic [31:0] remaining,
  input logic        wr_beat,
  input logic        chain_out,
  input logic [3:0]  chain_target
);
  a_r2_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
  a_r2_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && size == 2'd0) |-> $countones(wr_be) == 1);
  a_r7_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));
  a_r10_no_self_chain: assert property (@(posedge clk) disable iff (!rst_n)
    chain_out |-> (chain_target != 4'(CH_ID)));
  a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat |=> (remaining == $past(remaining) - 32'd1));
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !wr_req));
endmodule

bind dma_ring_chan dma_ring_chan_chk #(.CH_ID(CH_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .wr_req(wr_req), .wr_be(wr_be), .size(cf_size), .busy(busy), .remaining(remaining),
  .wr_beat(wr_beat), .chain_out(chain_out), .chain_target(chain_target)
);

// File: tb/dma_ring_chan_bench.sv
module dma_ring_chan_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = 3'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        rd_req, rd_ready = 1'b0, rd_fault = 1'b0;
  logic [31:0] rd_addr, rd_data = '0;
  logic        wr_req, wr_ready = 1'b0, wr_fault = 1'b0;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be, chain_target;
  logic [3:0]  pace_req = 4'd0;
  logic        chain_in = 1'b0, chain_out, irq;

  int checks = 0, errors = 0, irq_cnt = 0, chain_cnt = 0, rd_seen = 0, rep_bad = 0;
  logic [3:0]  last_target = '0;
  logic [31:0] mem [256];
  logic [31:0] gold [256];
  logic [31:0] exp_rp, exp_wp;
  logic        rd_fault_arm = 0, wr_fault_arm = 0;
  logic [31:0] fault_addr = '0;

  always #10 clk = ~clk;

  dma_ring_chan u_dma_ring_chan (.*);

  // Memory model: random wait states, decisions made away from the active edge.
  always @(negedge clk) begin
    rd_ready = rd_req && ($urandom % 3 != 0);
    rd_data  = mem[rd_addr[9:2]];
    rd_fault = rd_ready && rd_fault_arm && (rd_addr == fault_addr);
    wr_ready = wr_req && ($urandom % 3 != 0);
    wr_fault = wr_ready && wr_fault_arm && (wr_addr == fault_addr);
    if (irq) irq_cnt++;
    if (chain_out) begin chain_cnt++; last_target = chain_target; end
    if (rd_req) rd_seen++;
    if (wr_req && wr_be != 4'hF && wr_data[15:0] != wr_data[31:16]) rep_bad++;
  end
  always @(posedge clk)
    if (wr_req && wr_ready && !wr_fault)
      for (int b = 0; b < 4; b++)
        if (wr_be[b]) mem[wr_addr[9:2]][8*b +: 8] <= wr_data[8*b +: 8];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk); reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] idx, output logic [31:0] val);
    @(negedge clk); reg_idx = idx; #1; val = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int t = 0; t < 3000; t++) begin
      rreg(3'd0, v);
      if (!v[24]) return;
    end
    chk(0, "R12 busy never fell", 32'd1, 32'd0);
  endtask

  function automatic logic [31:0] mk(input int size, input bit ir, input bit iw, input int ring,
                                     input bit rwr, input int chn, input int pace, input bit quiet,
                                     input bit swp);
    return 32'(1 | (size << 1) | (ir << 3) | (iw << 4) | (ring << 5) | (rwr << 9) |
               (chn << 10) | (pace << 14) | (quiet << 20) | (swp << 21));
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] a, input int size, input bit inc, input bit wrap, input int ring);
    int st = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    int win = 1 << ring;
    if (!inc) return a;
    if (wrap && ring != 0) return a - (a % win) + ((a + st) % win);
    return a + st;
  endfunction

  // Golden model of one sequence applied to the gold memory image.
  task automatic model(input logic [31:0] c, input logic [31:0] src, input logic [31:0] dst, input int cnt);
    int size = int'(c[2:1]);
    int ring = int'(c[8:5]);
    logic [31:0] w, e;
    exp_rp = src; exp_wp = dst;
    for (int i = 0; i < cnt; i++) begin
      w = gold[exp_rp[9:2]];
      if (size == 0) begin
        e = (w >> (8 * exp_rp[1:0])) & 32'hFF;
        gold[exp_wp[9:2]][8*exp_wp[1:0] +: 8] = e[7:0];
      end else if (size == 1) begin
        e = (w >> (exp_rp[1] ? 16 : 0)) & 32'hFFFF;
        if (c[21]) e = {16'h0, e[7:0], e[15:8]};
        gold[exp_wp[9:2]][(exp_wp[1] ? 16 : 0) +: 16] = e[15:0];
      end else begin
        e = c[21] ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
        gold[exp_wp[9:2]] = e;
      end
      exp_rp = nxt(exp_rp, size, c[3], !c[9], ring);
      exp_wp = nxt(exp_wp, size, c[4], c[9], ring);
    end
  endtask

  task automatic mem_cmp(input string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== gold[i]) bad++;
    chk(bad == 0, tag, 32'(bad), 32'd0);
  endtask

  task automatic job(input logic [31:0] c, input logic [31:0] src, input logic [31:0] dst, input int cnt);
    wreg(3'd0, c & ~32'd1);
    wreg(3'd1, src);
    wreg(3'd2, dst);
    wreg(3'd3, 32'(cnt));
    wreg(3'd4, c);
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, c, src, dst;
    int n, i0;
    void'($urandom(32'd7331));
    for (int i = 0; i < 256; i++) begin mem[i] = $urandom; gold[i] = mem[i]; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rreg(3'd0, v); chk(v == 0, "R1 ctrl after reset", v, 0);
    rreg(3'd3, v); chk(v == 0, "R1 count after reset", v, 0);
    chk(!rd_req && !wr_req && !irq && !chain_out, "R1 outputs idle",
        {28'd0, rd_req, wr_req, irq, chain_out}, 0);

    // R3 R8: plain word copy
    c = mk(2, 1, 1, 0, 0, 0, 63, 0, 0);
    model(c, 32'h000, 32'h200, 8); i0 = irq_cnt;
    job(c, 32'h000, 32'h200, 8);
    mem_cmp("R3 word copy data");
    rreg(3'd1, v); chk(v == exp_rp, "R3 read pointer end", v, exp_rp);
    rreg(3'd2, v); chk(v == exp_wp, "R3 write pointer end", v, exp_wp);
    rreg(3'd3, v); chk(v == 0, "R12 remaining after end", v, 0);
    chk(irq_cnt == i0 + 1, "R8 irq at end", 32'(irq_cnt - i0), 1);
    chk(chain_cnt == 0, "R10 self target no chain", 32'(chain_cnt), 0);

    // R2: byte run into a fixed write address, lanes replicated
    c = mk(0, 1, 0, 0, 0, 0, 63, 0, 0);
    model(c, 32'h041, 32'h303, 3); rep_bad = 0;
    job(c, 32'h041, 32'h303, 3);
    mem_cmp("R2 byte lanes fixed dst");
    chk(rep_bad == 0, "R2 narrow data replicated", 32'(rep_bad), 0);

    // R2 R4 R5 R6: random mixes
    for (int r = 0; r < 10; r++) begin
      n = 1 + $urandom % 12;
      c = mk($urandom % 3, 1'($urandom), 1'($urandom), ($urandom % 2) ? 3 + $urandom % 4 : 0,
             1'($urandom), 0, 63, 0, 1'($urandom));
      src = 32'(($urandom % 96) << 2);
      dst = 32'h200 + 32'(($urandom % 96) << 2);
      model(c, src, dst, n);
      job(c, src, dst, n);
      mem_cmp("R4 R5 R6 random mix data");
      rreg(3'd1, v); chk(v == exp_rp, "R4 R5 random read pointer", v, exp_rp);
      rreg(3'd2, v); chk(v == exp_wp, "R4 R5 random write pointer", v, exp_wp);
    end

    // R7 R12: paced by line 1, held low
    c = mk(2, 1, 1, 0, 0, 0, 1, 0, 0);
    model(c, 32'h080, 32'h280, 2);
    wreg(3'd0, c & ~32'd1); wreg(3'd1, 32'h080); wreg(3'd2, 32'h280); wreg(3'd3, 2);
    rd_seen = 0;
    wreg(3'd4, c);
    repeat (20) @(negedge clk);
    chk(rd_seen == 0, "R7 no beat while request low", 32'(rd_seen), 0);
    rreg(3'd0, v); chk(v[24], "R12 busy while waiting", v, 32'h0100_0000);
    rreg(3'd6, v); chk(v == 2, "R12 remaining before beats", v, 2);
    pace_req = 4'b0010;
    wait_idle(); pace_req = 4'b0000;
    mem_cmp("R7 paced copy data");

    // R9: quiet completion, then zero launch write
    c = mk(1, 1, 1, 0, 0, 0, 63, 1, 1);
    model(c, 32'h0C0, 32'h2C0, 4); i0 = irq_cnt;
    job(c, 32'h0C0, 32'h2C0, 4);
    repeat (2) @(negedge clk);
    chk(irq_cnt == i0, "R9 quiet end no irq", 32'(irq_cnt - i0), 0);
    mem_cmp("R9 quiet half swap data");
    wreg(3'd4, 32'd0);
    repeat (2) @(negedge clk);
    chk(irq_cnt == i0 + 1, "R9 zero launch irq", 32'(irq_cnt - i0), 1);
    rreg(3'd0, v); chk(!v[24], "R9 zero launch no start", v, 0);

    // R10: chain to channel 5, then start from chain_in
    c = mk(2, 1, 1, 0, 0, 5, 63, 0, 0);
    model(c, 32'h100, 32'h300, 2); n = chain_cnt;
    job(c, 32'h100, 32'h300, 2);
    repeat (2) @(negedge clk);
    chk(chain_cnt == n + 1 && last_target == 5, "R10 chain pulse target",
        {28'(chain_cnt - n), last_target}, {28'd1, 4'd5});
    c = mk(2, 1, 1, 0, 0, 0, 63, 0, 0);
    model(c, 32'h120, 32'h320, 3);
    wreg(3'd0, c); wreg(3'd1, 32'h120); wreg(3'd2, 32'h320); wreg(3'd3, 3);
    rreg(3'd0, v); chk(!v[24], "R13 plain slots no start", v, 0);
    @(negedge clk); chain_in = 1'b1; @(negedge clk); chain_in = 1'b0;
    wait_idle();
    mem_cmp("R10 chain_in start data");

    // R13: count alias then read-pointer launch slot
    c = mk(2, 1, 1, 0, 0, 0, 63, 0, 0);
    model(c, 32'h140, 32'h340, 3);
    wreg(3'd0, c); wreg(3'd2, 32'h340); wreg(3'd6, 3); wreg(3'd7, 32'h140);
    wait_idle();
    mem_cmp("R13 alias launch data");

    // R11: read fault on third beat, then write fault
    c = mk(2, 1, 1, 0, 0, 5, 63, 0, 0);
    fault_addr = 32'h168; rd_fault_arm = 1; i0 = irq_cnt; n = chain_cnt;
    job(c, 32'h160, 32'h360, 4);
    rd_fault_arm = 0;
    rreg(3'd0, v); chk(v[29] && v[31] && !v[24], "R11 read error flags", v, 32'hA000_0000);
    rreg(3'd3, v); chk(v == 2, "R11 stopped remaining", v, 2);
    chk(irq_cnt == i0 && chain_cnt == n, "R11 no irq or chain", 32'(irq_cnt - i0), 0);
    wreg(3'd0, 32'h2000_0000);
    rreg(3'd0, v); chk(v[31:29] == 0, "R11 read error cleared", v, 0);
    for (int i = 0; i < 256; i++) gold[i] = mem[i];
    fault_addr = 32'h384; wr_fault_arm = 1;
    job(c, 32'h180, 32'h380, 4);
    wr_fault_arm = 0;
    rreg(3'd0, v); chk(v[30] && v[31] && !v[29], "R11 write error flags", v, 32'hC000_0000);
    wreg(3'd4, 32'h4000_0000);
    rreg(3'd0, v); chk(v[31:29] == 0 && !v[24], "R11 write error cleared", v, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule